// File: doc/BRIEF.md
# Sector Header Compare Checker

This block checks the header of a disk sector as it comes off the read path. A deserializer hands it words, one per strobe. A framing pulse marks the start of each header. The header holds three words: a cylinder word, then a track/sector word, then a 16-bit CRC word. The block keeps a running CRC over the first two words. It also judges the status flags carried in the cylinder word and compares the address fields against a desired cylinder, track and sector.

The result appears one cycle after the CRC word is accepted. It is either a single-cycle match pulse or a single-cycle error pulse carrying one error code. A result is produced only if the external sector-count match input is high when the CRC word arrives. Without that match, the header belonged to some other sector and is silently dropped. A compare-inhibit input suppresses only the address comparison. The CRC and flag checks still apply while it is high.

The sequencer has four states. IDLE waits for a header. CYL waits for the cylinder word, TRK waits for the track/sector word, and CRCW waits for the CRC word. The transitions are as follows. A start pulse in any state goes to CYL. An accepted word moves CYL to TRK and TRK to CRCW. An accepted word in CRCW returns the sequencer to IDLE and launches the result.

Top module: `hdr_chk`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `match_o` and `err_o` are 0 and `err_code_o` is 0 (none).
- R2: After `hdr_begin`, the first three words with `word_valid` high are taken as cylinder word, track/sector word and CRC word. Idle cycles may sit between them. The result is visible in the cycle after the clock edge that accepts the CRC word. `hdr_begin` restarts the sequence from any state, and a word offered in the same cycle as `hdr_begin` is dropped. Words offered outside a header give no result.
- R3: The expected CRC uses polynomial 0x1021 with seed 0xFFFF. It is computed MSB first over the cylinder word and then the track/sector word. A CRC word that differs from it gives error code 1.
- R4: If bit 12 of the cylinder word is 0, the error code is 2 (format).
- R5: If bits 15 and 14 of the cylinder word are not both 1, the error code is 3 (bad sector).
- R6: If bit 13 of the cylinder word is 1 (sector relocated), the error code is 4 (skip sector).
- R7: If cylinder-word bits [CYL_W-1:0] differ from `des_cyl`, or bits [15:8] of the track/sector word differ from `des_trk`, or bits [7:0] differ from `des_sec`, the error code is 5 (compare).
- R8: Only one error is reported. Priority runs CRC (1), format (2), bad sector (3), skip (4), compare (5). `match_o` and `err_o` are never high together, and `err_code_o` is nonzero exactly when `err_o` is high.
- R9: With no error present, `match_o` pulses for one cycle and `err_code_o` stays 0.
- R10: If `sect_hit` is low at the CRC word, neither `match_o` nor `err_o` is raised.
- R11: While `cmp_inhibit` is high at the CRC word, code 5 is never produced. An address mismatch then gives a match, but codes 1 to 4 still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_begin | input | 1 | Start-of-header pulse |
| word_valid | input | 1 | Word strobe |
| word_data | input | 16 | Deserialized header word |
| des_cyl | input | CYL_W | Desired cylinder |
| des_trk | input | 8 | Desired track |
| des_sec | input | 8 | Desired sector |
| sect_hit | input | 1 | Running sector count equals desired sector |
| cmp_inhibit | input | 1 | Suppress the address comparison |
| match_o | output | 1 | Header matched, one-cycle pulse |
| err_o | output | 1 | Header error, one-cycle pulse |
| err_code_o | output | 3 | Error code (0 none, 1 CRC, 2 format, 3 bad, 4 skip, 5 compare) |

## Verification
Several properties are checked on every cycle. Match and error are never raised together, and the code agrees with the error pulse. A result appears only in the cycle after a CRC word is accepted. An unqualified sector and the inhibit input each keep their effect. The start pulse always lands in CYL, and the CRC register is reseeded on each start. The bench's scenarios are needed for the rest: the CRC value itself, each flag decode, the address compare, the priority among coexisting faults, restarts in mid-header, and gaps between words.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

    typedef enum logic [2:0] {
        HE_NONE = 3'd0,
        HE_CRC  = 3'd1,
        HE_FMT  = 3'd2,
        HE_BAD  = 3'd3,
        HE_SKIP = 3'd4,
        HE_CMP  = 3'd5
    } hdr_err_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CYL  = 2'd1,
        ST_TRK  = 2'd2,
        ST_CRCW = 2'd3
    } hdr_state_e;

    localparam int HDR_WORD_W = 16;
    localparam int FLAG_FMT   = 12;
    localparam int FLAG_SKIP  = 13;
    localparam int FLAG_OK_LO = 14;
    localparam int FLAG_OK_HI = 15;

    function automatic logic [15:0] crc16_step(input logic [15:0] seed,
                                               input logic [15:0] din,
                                               input logic [15:0] poly);
        logic [15:0] c;
        logic        fb;
        c = seed;
        for (int i = 15; i >= 0; i--) begin
            fb = c[15] ^ din[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/hdr_crc_acc.sv
module hdr_crc_acc
    import hdr_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [15:0] din,
    output logic [15:0] crc_o
);

    logic [15:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= SEED;
        end else if (en) begin
            acc_q <= crc16_step(acc_q, din, POLY);
        end
    end

    assign crc_o = acc_q;

    // R3: every new header starts from the seed value
    assert_crc_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_o == SEED));

endmodule

// File: rtl/hdr_judge.sv
module hdr_judge
    import hdr_pkg::*;
#(
    parameter int CYL_W = 10
) (
    input  logic [15:0]      cyl_word,
    input  logic [15:0]      ts_word,
    input  logic [15:0]      crc_calc,
    input  logic [15:0]      crc_word,
    input  logic [CYL_W-1:0] des_cyl,
    input  logic [7:0]       des_trk,
    input  logic [7:0]       des_sec,
    input  logic             inhibit,
    output hdr_err_e         code
);

    localparam int BYTE_W = HDR_WORD_W / 2;

    logic crc_bad, fmt_bad, sec_bad, skip_set, addr_diff;

    always_comb begin
        crc_bad   = (crc_calc != crc_word);
        fmt_bad   = !cyl_word[FLAG_FMT];
        sec_bad   = !(cyl_word[FLAG_OK_HI] && cyl_word[FLAG_OK_LO]);
        skip_set  = cyl_word[FLAG_SKIP];
        addr_diff = (cyl_word[CYL_W-1:0] != des_cyl)
                 || (ts_word[HDR_WORD_W-1:BYTE_W] != des_trk)
                 || (ts_word[BYTE_W-1:0] != des_sec);
    end

    always_comb begin
        if (crc_bad)                     code = HE_CRC;
        else if (fmt_bad)                code = HE_FMT;
        else if (sec_bad)                code = HE_BAD;
        else if (skip_set)               code = HE_SKIP;
        else if (addr_diff && !inhibit)  code = HE_CMP;
        else                             code = HE_NONE;
    end

endmodule

// File: rtl/hdr_chk.sv
module hdr_chk
    import hdr_pkg::*;
#(
    parameter int          CYL_W     = 10,
    parameter logic [15:0] CRC_POLY  = 16'h1021,
    parameter logic [15:0] CRC_SEED  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_begin,
    input  logic             word_valid,
    input  logic [15:0]      word_data,
    input  logic [CYL_W-1:0] des_cyl,
    input  logic [7:0]       des_trk,
    input  logic [7:0]       des_sec,
    input  logic             sect_hit,
    input  logic             cmp_inhibit,
    output logic             match_o,
    output logic             err_o,
    output logic [2:0]       err_code_o
);

    hdr_state_e  state_q, state_nx;
    logic [15:0] cyl_q, ts_q;
    logic [15:0] crc_now;
    logic        take_word, take_crc, crc_en;
    hdr_err_e    verdict;

    assign take_word = word_valid && !hdr_begin;
    assign take_crc  = take_word && (state_q == ST_CRCW);
    assign crc_en    = take_word && ((state_q == ST_CYL) || (state_q == ST_TRK));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        if (hdr_begin) begin
            state_nx = ST_CYL;
        end else if (word_valid) begin
            unique case (state_q)
                ST_IDLE: state_nx = ST_IDLE;
                ST_CYL:  state_nx = ST_TRK;
                ST_TRK:  state_nx = ST_CRCW;
                ST_CRCW: state_nx = ST_IDLE;
            endcase
        end
    end

    // header word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyl_q <= '0;
            ts_q  <= '0;
        end else if (take_word) begin
            if (state_q == ST_CYL) cyl_q <= word_data;
            if (state_q == ST_TRK) ts_q  <= word_data;
        end
    end

    hdr_crc_acc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hdr_begin),
        .en    (crc_en),
        .din   (word_data),
        .crc_o (crc_now)
    );

    hdr_judge #(.CYL_W(CYL_W)) u_judge (
        .cyl_word (cyl_q),
        .ts_word  (ts_q),
        .crc_calc (crc_now),
        .crc_word (word_data),
        .des_cyl  (des_cyl),
        .des_trk  (des_trk),
        .des_sec  (des_sec),
        .inhibit  (cmp_inhibit),
        .code     (verdict)
    );

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o    <= 1'b0;
            err_o      <= 1'b0;
            err_code_o <= HE_NONE;
        end else begin
            match_o    <= 1'b0;
            err_o      <= 1'b0;
            err_code_o <= HE_NONE;
            if (take_crc && sect_hit) begin
                if (verdict == HE_NONE) match_o <= 1'b1;
                else begin
                    err_o      <= 1'b1;
                    err_code_o <= verdict;
                end
            end
        end
    end

    assert_single_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_o && err_o));

    assert_code_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (err_code_o != 3'd0));

    assert_result_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o || err_o) |-> $past(take_crc));

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_begin |=> (state_q == ST_CYL));

    assert_unqualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_crc && !sect_hit) |=> (!match_o && !err_o));

    assert_inhibit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_crc && cmp_inhibit) |=> (err_code_o != 3'd5));

endmodule

// File: tb/hdr_chk_test.sv
module hdr_chk_test;

    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_begin = 1'b0;
    logic          word_valid = 1'b0;
    logic [15:0]   word_data = '0;
    logic [CW-1:0] des_cyl = '0;
    logic [7:0]    des_trk = '0;
    logic [7:0]    des_sec = '0;
    logic          sect_hit = 1'b1;
    logic          cmp_inhibit = 1'b0;
    logic          match_o, err_o;
    logic [2:0]    err_code_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hdr_chk #(.CYL_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .hdr_begin(hdr_begin), .word_valid(word_valid),
        .word_data(word_data), .des_cyl(des_cyl), .des_trk(des_trk), .des_sec(des_sec),
        .sect_hit(sect_hit), .cmp_inhibit(cmp_inhibit),
        .match_o(match_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    // bit-serial CRC over the 32-bit address pair (R3)
    function automatic logic [15:0] ref_crc(input logic [31:0] d);
        logic [15:0] c = 16'hFFFF;
        for (int i = 31; i >= 0; i--)
            c = {c[14:0], 1'b0} ^ ((c[15] ^ d[i]) ? 16'h1021 : 16'h0000);
        return c;
    endfunction

    // ---------------- reference model ----------------
    int         phase = 0;
    logic [15:0] wq[$];
    logic       exp_hit = 0, exp_err = 0;
    logic [2:0] exp_code = 0;
    bit         in_reset = 1;

    always @(posedge clk) begin
        int code;
        exp_hit  <= 0;
        exp_err  <= 0;
        exp_code <= 0;
        in_reset <= !rst_n;
        if (!rst_n) begin
            phase = 0;
            wq.delete();
        end else if (hdr_begin) begin
            phase = 1;
            wq.delete();
        end else if (word_valid && phase != 0) begin
            if (phase < 3) begin
                wq.push_back(word_data);
                phase++;
            end else begin
                code = 0;
                if (word_data != ref_crc({wq[0], wq[1]}))      code = 1;
                else if (wq[0][12] == 1'b0)                   code = 2;
                else if (!(wq[0][15] && wq[0][14]))           code = 3;
                else if (wq[0][13])                           code = 4;
                else if (!cmp_inhibit &&
                         (wq[0][CW-1:0] != des_cyl || wq[1] != {des_trk, des_sec}))
                                                              code = 5;
                if (sect_hit) begin
                    if (code == 0) exp_hit <= 1;
                    else begin
                        exp_err  <= 1;
                        exp_code <= 3'(code);
                    end
                end
                phase = 0;
                wq.delete();
            end
        end
    end

    function automatic string tag_of(input bit rst, input logic h, input logic [2:0] c);
        if (rst) return "R1";
        if (h)   return "R9";
        case (c)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R2/R10";
        endcase
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            total++;
            if (match_o !== exp_hit || err_o !== exp_err || err_code_o !== exp_code) begin
                bad++;
                $display("FAIL %s t=%0t actual match=%b err=%b code=%0d expected match=%b err=%b code=%0d",
                         tag_of(in_reset, exp_hit, exp_code), $time,
                         match_o, err_o, err_code_o, exp_hit, exp_err, exp_code);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(input logic [15:0] w);
        word_valid = 1; word_data = w;
        @(negedge clk);
        word_valid = 0; word_data = 16'hA5A5;
    endtask

    task automatic start();
        hdr_begin = 1;
        @(negedge clk);
        hdr_begin = 0;
    endtask

    task automatic header(input logic [15:0] w1, input logic [15:0] w2,
                          input logic [15:0] c, input int gap);
        start();
        put(w1); idle(gap);
        put(w2); idle(gap);
        put(c);
        idle(2);
    endtask

    task automatic good(input logic [15:0] w1, input logic [15:0] w2, input int gap);
        header(w1, w2, ref_crc({w1, w2}), gap);
    endtask

    logic [15:0] gw1, gw2;

    initial begin
        idle(3);                       // R1: reset state checked each clock
        rst_n = 1;
        idle(2);                       // R1: first cycle after reset
        des_cyl = 10'h155; des_trk = 8'h07; des_sec = 8'h1F;
        gw1 = 16'hD000 | 16'h0155;
        gw2 = {8'h07, 8'h1F};

        good(gw1, gw2, 0);                              // R9 match
        good(gw1, gw2, 3);                              // R2 gaps between words
        header(gw1, gw2, ref_crc({gw1, gw2}) ^ 16'h0100, 0);  // R3 CRC error
        good(gw1 & ~16'h1000, gw2, 0);                  // R4 format
        good(gw1 & ~16'h4000, gw2, 1);                  // R5 bad sector
        good(gw1 & ~16'h8000, gw2, 0);                  // R5 bad sector
        good(gw1 | 16'h2000, gw2, 0);                   // R6 skip
        good(gw1 ^ 16'h0001, gw2, 0);                   // R7 cylinder differs
        good(gw1, gw2 ^ 16'h0100, 0);                   // R7 track differs
        good(gw1, gw2 ^ 16'h0001, 0);                   // R7 sector differs
        good(gw1 | 16'h0C00, gw2, 0);                   // R7 bits above CYL_W ignored
        header(gw1 & ~16'h1000, gw2, 16'h0000, 0);      // R8 CRC over format
        good(gw1 & ~16'h5000, gw2, 0);                  // R8 format over bad
        good((gw1 & ~16'h4000) | 16'h2000, gw2, 0);     // R8 bad over skip
        good((gw1 | 16'h2000) ^ 16'h0003, gw2, 0);      // R8 skip over compare

        cmp_inhibit = 1;
        good(gw1 ^ 16'h0003, gw2 ^ 16'h0202, 0);        // R11 mismatch becomes match
        good(gw1 & ~16'h1000, gw2, 0);                  // R11 format still reported
        header(gw1, gw2, 16'h1234, 0);                  // R11 CRC still reported
        cmp_inhibit = 0;

        sect_hit = 0;
        good(gw1, gw2, 0);                              // R10 no result
        header(gw1, gw2, 16'h0000, 0);                  // R10 error suppressed
        sect_hit = 1;

        // R2: words without a start pulse give nothing
        put(gw1); put(gw2); put(ref_crc({gw1, gw2})); idle(2);
        // R2: restart mid-header
        start(); put(16'h0000); start();
        put(gw1); put(gw2); put(ref_crc({gw1, gw2})); idle(2);
        // R2: word in the start cycle is dropped
        hdr_begin = 1; word_valid = 1; word_data = 16'hFFFF;
        @(negedge clk);
        hdr_begin = 0; word_valid = 0;
        put(gw1); put(gw2); put(ref_crc({gw1, gw2})); idle(2);
        // R2: back-to-back headers
        good(gw1, gw2, 0);
        des_cyl = 10'h3FF; des_trk = 8'hFF; des_sec = 8'h00;
        good(16'hD3FF, 16'hFF00, 0);                    // R9 extreme addresses
        // R1: reset in mid-header clears the sequence
        start(); put(gw1); rst_n = 0; idle(2); rst_n = 1;
        put(16'hFF00); put(ref_crc({16'hD3FF, 16'hFF00})); idle(3);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule